// File: doc/BRIEF.md
# Dual-Channel Shutdown State Controller

This block keeps the power state of two converter output channels and of the bias and reference circuit they share. It receives already-deserialised command words, single-cycle pulses that mark a channel's output register being written, and an active-low lockout pin. From these it drives a per-channel enable, a per-channel output termination select, a bias enable and a settle-ready flag. The block never touches the data registers, so a channel that wakes resumes whatever code it held before it was shut down.

A shutdown can target one channel, both channels with the bias left running, or both channels with the bias also turned off (full power-down). Each shutdown records whether the idle output should see a light (high-ohm) or a heavy (low-ohm) termination. A channel leaves shutdown when its output register is written, and any wake restores the bias. The lockout pin blocks every shutdown while it is low. Its falling edge wakes everything that is asleep. The pulse that loads both output registers together from the input registers must not be routed to the update inputs, because that load leaves sleeping channels asleep. Commands carry no back-pressure: `cmd_valid` is taken in every cycle it is high, and there is no ready signal.

Top module: `dac_pwr_ctrl`

## Requirements
- R1: After reset both channels are enabled, both termination selects are 0, `bias_en` is 1 and `ready` is 1.
- R2: A command with `cmd_code` = 3'b111 shuts down both channels. `term_hi_a` takes `cmd_data[11]` and `term_hi_b` takes `cmd_data[10]`. `bias_en` is left unchanged. Outputs change on the clock edge that samples the command.
- R3: A command with `cmd_code` = 3'b000 and `cmd_data[11:9]` = 3'b011 shuts down both channels and clears `bias_en`. `term_hi_a` takes `cmd_data[8]` and `term_hi_b` takes `cmd_data[7]`.
- R4: With `cmd_code` = 3'b000, `cmd_data[11:9]` = 3'b110 shuts down channel A only and 3'b111 shuts down channel B only. In both cases the termination comes from `cmd_data[8]`. The other channel is untouched, and every other code leaves the power state as it was.
- R5: A pulse on `upd_a` or `upd_b` enables that channel only and sets `bias_en`. In the same cycle, an update beats a shutdown of the same channel.
- R6: While `lock_n` is low, every shutdown command is ignored.
- R7: A high-to-low edge on `lock_n` while any channel is shut down enables both channels and sets `bias_en`. The termination selects keep their values.
- R8: Once `bias_en` is 0, further shutdown commands leave it at 0. Only a wake sets it again.
- R9: A wake that enables a disabled channel drops `ready`. `ready` returns high exactly `SETTLE_SHORT` cycles after the wake edge, or `SETTLE_LONG` cycles if `bias_en` was 0 when the wake was sampled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command word present this cycle |
| cmd_code | input | 3 | Command code field |
| cmd_data | input | 12 | Command data field |
| upd_a | input | 1 | Channel A output register written |
| upd_b | input | 1 | Channel B output register written |
| lock_n | input | 1 | Shutdown lockout, active low |
| en_a | output | 1 | Channel A enabled |
| en_b | output | 1 | Channel B enabled |
| term_hi_a | output | 1 | Channel A idle termination: 1 high-ohm, 0 low-ohm |
| term_hi_b | output | 1 | Channel B idle termination: 1 high-ohm, 0 low-ohm |
| bias_en | output | 1 | Shared bias and reference enabled |
| ready | output | 1 | Outputs settled after the last wake |

## Verification
Every command, update pulse and lockout edge is sampled on a rising edge and shows up on the power outputs straight after that same edge, a latency of one cycle. The bench therefore drives stimulus on a falling edge and checks at the next falling edge. For `ready` the bench counts rising edges from the wake: the flag must still be low after `SETTLE_SHORT`−1 (or `SETTLE_LONG`−1) further edges and high after one more, so an off-by-one in the counter shows up.

// File: rtl/dpc_pkg.sv
`timescale 1ns/1ps
package dpc_pkg;
  localparam logic [2:0] OP_SD_BOTH  = 3'b111;
  localparam logic [2:0] OP_EXT      = 3'b000;
  localparam logic [2:0] SUB_FULL_PD = 3'b011;
  localparam logic [2:0] SUB_SD_A    = 3'b110;
  localparam logic [2:0] SUB_SD_B    = 3'b111;

  typedef struct packed {
    logic [1:0] sd;      // index 0 = channel A
    logic [1:0] term;
    logic       full_pd;
  } sd_req_t;
endpackage

// File: rtl/dpc_cmd_decode.sv
`timescale 1ns/1ps
module dpc_cmd_decode
  import dpc_pkg::*;
#(
  parameter int DW = 12
) (
  input  logic          cmd_valid,
  input  logic [2:0]    cmd_code,
  input  logic [DW-1:0] cmd_data,
  input  logic          lock_n,
  output sd_req_t       req
);
  localparam int SUB_HI = DW - 1;
  localparam int SUB_LO = DW - 3;
  localparam int T1_BIT = DW - 4;
  localparam int T2_BIT = DW - 5;

  logic unused_low;
  assign unused_low = ^cmd_data[T2_BIT-1:0];

  always_comb begin
    req = '0;
    if (cmd_valid && lock_n) begin
      unique case (cmd_code)
        OP_SD_BOTH: begin
          req.sd   = 2'b11;
          req.term = {cmd_data[SUB_HI-1], cmd_data[SUB_HI]};
        end
        OP_EXT: begin
          unique case (cmd_data[SUB_HI:SUB_LO])
            SUB_FULL_PD: begin
              req.sd      = 2'b11;
              req.full_pd = 1'b1;
              req.term    = {cmd_data[T2_BIT], cmd_data[T1_BIT]};
            end
            SUB_SD_A: begin
              req.sd[0]   = 1'b1;
              req.term[0] = cmd_data[T1_BIT];
            end
            SUB_SD_B: begin
              req.sd[1]   = 1'b1;
              req.term[1] = cmd_data[T1_BIT];
            end
            default: ;
          endcase
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    if (!lock_n) AST_LOCK_NO_REQ: assert (req == '0); // R6
  end
endmodule

// File: rtl/dpc_chan.sv
`timescale 1ns/1ps
module dpc_chan (
  input  logic clk,
  input  logic rst_n,
  input  logic sd,
  input  logic term_in,
  input  logic wake,
  output logic en,
  output logic term_hi
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en      <= 1'b1;
      term_hi <= 1'b0;
    end else begin
      if (sd) term_hi <= term_in;
      if (wake)    en <= 1'b1;
      else if (sd) en <= 1'b0;
    end
  end

  AST_WAKE_ENABLES: assert property (@(posedge clk) disable iff (!rst_n)
    wake |=> en); // R5
  AST_SD_DISABLES: assert property (@(posedge clk) disable iff (!rst_n)
    (sd && !wake) |=> !en); // R2
endmodule

// File: rtl/dpc_settle.sv
`timescale 1ns/1ps
module dpc_settle #(
  parameter int SETTLE_SHORT = 8,
  parameter int SETTLE_LONG  = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic long_sel,
  output logic ready
);
  localparam int MAXC = (SETTLE_LONG > SETTLE_SHORT) ? SETTLE_LONG : SETTLE_SHORT;
  localparam int CW   = $clog2(MAXC + 1);
  localparam logic [CW-1:0] LD_SHORT = CW'(SETTLE_SHORT);
  localparam logic [CW-1:0] LD_LONG  = CW'(SETTLE_LONG);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cnt <= '0;
    else if (start)       cnt <= long_sel ? LD_LONG : LD_SHORT;
    else if (cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign ready = (cnt == '0);

  AST_WAKE_DROPS_READY: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !ready); // R9
endmodule

// File: rtl/dac_pwr_ctrl.sv
`timescale 1ns/1ps
module dac_pwr_ctrl
  import dpc_pkg::*;
#(
  parameter int DW           = 12,
  parameter int SETTLE_SHORT = 8,
  parameter int SETTLE_LONG  = 20
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  input  logic [2:0]    cmd_code,
  input  logic [DW-1:0] cmd_data,
  input  logic          upd_a,
  input  logic          upd_b,
  input  logic          lock_n,
  output logic          en_a,
  output logic          en_b,
  output logic          term_hi_a,
  output logic          term_hi_b,
  output logic          bias_en,
  output logic          ready
);
  localparam int NCH = 2;

  sd_req_t        req;
  logic           lock_prev;
  logic           lock_fall;
  logic           pin_wake;
  logic [NCH-1:0] upd;
  logic [NCH-1:0] wake;
  logic [NCH-1:0] en;
  logic [NCH-1:0] term;
  logic           settle_go;

  dpc_cmd_decode #(.DW(DW)) u_dec (
    .cmd_valid (cmd_valid),
    .cmd_code  (cmd_code),
    .cmd_data  (cmd_data),
    .lock_n    (lock_n),
    .req       (req)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lock_prev <= 1'b1;
    else        lock_prev <= lock_n;
  end

  assign lock_fall = lock_prev && !lock_n;
  assign pin_wake  = lock_fall && (en != {NCH{1'b1}});
  assign upd       = {upd_b, upd_a};
  assign wake      = upd | {NCH{pin_wake}};

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    dpc_chan u_ch (
      .clk     (clk),
      .rst_n   (rst_n),
      .sd      (req.sd[i]),
      .term_in (req.term[i]),
      .wake    (wake[i]),
      .en      (en[i]),
      .term_hi (term[i])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            bias_en <= 1'b1;
    else if (|wake)        bias_en <= 1'b1;
    else if (req.full_pd)  bias_en <= 1'b0;
  end

  assign settle_go = |(wake & ~en);

  dpc_settle #(.SETTLE_SHORT(SETTLE_SHORT), .SETTLE_LONG(SETTLE_LONG)) u_settle (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (settle_go),
    .long_sel (!bias_en),
    .ready    (ready)
  );

  assign en_a      = en[0];
  assign en_b      = en[1];
  assign term_hi_a = term[0];
  assign term_hi_b = term[1];

  AST_LOCK_KEEPS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    !lock_n |=> !($fell(en_a) || $fell(en_b))); // R6
  AST_BIAS_OFF_ALL_SHUT: assert property (@(posedge clk) disable iff (!rst_n)
    !bias_en |-> (!en_a && !en_b)); // R3
  AST_PIN_WAKE_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_prev && !lock_n && !(en_a && en_b)) |=> (en_a && en_b && bias_en)); // R7
  AST_BIAS_STAYS_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (!bias_en && !upd_a && !upd_b && !(lock_prev && !lock_n)) |=> !bias_en); // R8
endmodule

// File: tb/tb_dac_pwr_ctrl.sv
`timescale 1ns/1ps
module tb_dac_pwr_ctrl;
  localparam int SHORT = 8;
  localparam int LONG  = 20;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic [2:0]  cmd_code = '0;
  logic [11:0] cmd_data = '0;
  logic        upd_a = 1'b0, upd_b = 1'b0, lock_n = 1'b1;
  logic        en_a, en_b, term_hi_a, term_hi_b, bias_en, ready;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  dac_pwr_ctrl #(.DW(12), .SETTLE_SHORT(SHORT), .SETTLE_LONG(LONG)) dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
    .cmd_data(cmd_data), .upd_a(upd_a), .upd_b(upd_b), .lock_n(lock_n),
    .en_a(en_a), .en_b(en_b), .term_hi_a(term_hi_a), .term_hi_b(term_hi_b),
    .bias_en(bias_en), .ready(ready)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // state as {en_b, en_a, term_hi_b, term_hi_a, bias_en}
  function automatic logic [4:0] st();
    return {en_b, en_a, term_hi_b, term_hi_a, bias_en};
  endfunction

  task automatic step(input logic v, input logic [2:0] c, input logic [11:0] d,
                      input logic ua, input logic ub);
    @(negedge clk);
    cmd_valid = v; cmd_code = c; cmd_data = d; upd_a = ua; upd_b = ub;
    @(negedge clk);
    cmd_valid = 1'b0; upd_a = 1'b0; upd_b = 1'b0;
  endtask

  task automatic wait_ready(input string tag, input int n);
    repeat (n - 1) @(negedge clk);
    chk({tag, " ready still low"}, ready, 1'b0);
    @(negedge clk);
    chk({tag, " ready back high"}, ready, 1'b1);
  endtask

  task automatic t_reset();
    chk("R1 reset state", st(), 5'b11_00_1);
    chk("R1 reset ready", ready, 1'b1);
  endtask

  task automatic t_both_sd();
    step(1'b1, 3'b111, 12'b10_0000000000, 1'b0, 1'b0);
    chk("R2 both shut, terms A=1 B=0, bias on", st(), 5'b00_01_1);
    step(1'b1, 3'b001, 12'hFFF, 1'b0, 1'b0);
    chk("R4 other code leaves state", st(), 5'b00_01_1);
    step(1'b0, 3'b000, 12'h0, 1'b1, 1'b0);
    chk("R5 update A wakes A only", st(), 5'b01_01_1);
    chk("R9 ready drops on wake", ready, 1'b0);
    wait_ready("R9 short settle", SHORT);
    step(1'b0, 3'b000, 12'h0, 1'b0, 1'b1);
    chk("R5 update B wakes B", st(), 5'b11_01_1);
  endtask

  task automatic t_single();
    step(1'b1, 3'b000, 12'b110_1_00000000, 1'b0, 1'b0);
    chk("R4 shut A only term 1", st(), 5'b10_01_1);
    step(1'b1, 3'b000, 12'b111_1_00000000, 1'b0, 1'b0);
    chk("R4 shut B only term 1", st(), 5'b00_11_1);
    step(1'b1, 3'b000, 12'b111_0_00000000, 1'b0, 1'b0);
    chk("R4 shut B again term 0", st(), 5'b00_01_1);
    step(1'b1, 3'b000, 12'b100_1_11111111, 1'b0, 1'b0);
    chk("R4 unlisted subcode ignored", st(), 5'b00_01_1);
    step(1'b0, 3'b000, 12'h0, 1'b1, 1'b1);
    chk("R5 both updates wake both", st(), 5'b11_01_1);
  endtask

  task automatic t_fpd();
    step(1'b1, 3'b000, 12'b011_1_0_0000000, 1'b0, 1'b0);
    chk("R3 full power-down", st(), 5'b00_01_0);
    step(1'b1, 3'b111, 12'b01_0000000000, 1'b0, 1'b0);
    chk("R8 both-shut keeps bias off", st(), 5'b00_10_0);
    step(1'b1, 3'b000, 12'b011_0_1_0000000, 1'b0, 1'b0);
    chk("R8 repeated full pd bias off", st(), 5'b00_10_0);
    step(1'b0, 3'b000, 12'h0, 1'b0, 1'b1);
    chk("R5 wake B from full pd restores bias", st(), 5'b10_10_1);
    wait_ready("R9 long settle", LONG);
    step(1'b0, 3'b000, 12'h0, 1'b1, 1'b0);
  endtask

  task automatic t_lock();
    @(negedge clk); lock_n = 1'b0;
    step(1'b1, 3'b111, 12'hFFF, 1'b0, 1'b0);
    chk("R6 shutdown ignored while locked", st(), 5'b11_10_1);
    step(1'b1, 3'b000, 12'b011_1_1_0000000, 1'b0, 1'b0);
    chk("R6 full pd ignored while locked", st(), 5'b11_10_1);
    @(negedge clk); lock_n = 1'b1;
    step(1'b1, 3'b000, 12'b011_1_1_0000000, 1'b0, 1'b0);
    chk("R3 full pd terms 1/1", st(), 5'b00_11_0);
    @(negedge clk); lock_n = 1'b0;
    @(negedge clk);
    chk("R7 lock edge wakes all, terms kept", st(), 5'b11_11_1);
    @(negedge clk); lock_n = 1'b1;
  endtask

  task automatic t_conflict();
    step(1'b1, 3'b111, 12'h000, 1'b1, 1'b0);
    chk("R5 update beats shutdown same cycle", st(), 5'b01_00_1);
    step(1'b0, 3'b000, 12'h0, 1'b0, 1'b1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_both_sd();
    t_single();
    t_fpd();
    t_lock();
    t_conflict();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule